// File: doc/BRIEF.md
# ETU Baud Generator

This block times the bit cells of a smart-card UART. It counts enabled cycles of the card clock and marks the end of each elementary time unit (ETU) with a one-cycle tick. It also gives a one-cycle sample strobe near the middle of the ETU, which the receiver uses to sample the line. The ETU length is the divider value multiplied by a prescaler. The prescaler is 31 or 32, and a software bit picks which.

A double-rate option runs the UART at twice the card frequency, which halves the ETU. The option is ignored while the card clock comes straight from the crystal. When the product is odd, a halved ETU has no whole length. The block then makes alternate ETUs one cycle longer, so that the average length stays exact. A resync input restarts the count, which lets a detected start bit set the ETU phase.

Control is a two-state machine. In state PH_EARLY the counter runs up to the mid point. The transition EARLY_TO_LATE raises the sample strobe. In state PH_LATE the counter runs to the end of the ETU. The transition LATE_TO_EARLY raises the tick, clears the counter and flips the alternation bit. A resync forces the transition ANY_TO_EARLY from either state.

Top module: `etu_baud_gen`

## Requirements
- R1: With the double-rate effect off, one ETU lasts P×D enabled cycles. P is 32 when `psc_is_32`=1 and 31 when it is 0. D is `div_val`.
- R2: A `div_val` of 0 gives the same timing as a `div_val` of 1.
- R3: When `dbl_rate`=1 and `src_is_xtal`=0, the ETU length is floor(P×D/2) plus an extra cycle. The extra cycle is added only when P×D is odd and the ETU's alternation bit is 1. The alternation bit is 0 after reset or resync and flips at every tick.
- R4: When `src_is_xtal`=1, `dbl_rate` has no effect on timing.
- R5: `sample_strobe` is a one-cycle pulse. It is high in the cycle after the enabled cycle whose ETU count index, counted from 0 at the start of the ETU, equals floor((L-1)/2), where L is the current ETU length.
- R6: `etu_tick` is a one-cycle pulse. It is high in the cycle after the L-th enabled cycle of the ETU, and it is never high in the same cycle as `sample_strobe`.
- R7: A cycle with `card_clk_en`=0 leaves the count unchanged, and neither output pulses in the next cycle.
- R8: `resync`=1 clears the count to 0 and the alternation bit to 0, and it overrides `card_clk_en`. Neither output pulses in the next cycle.
- R9: During reset both outputs are 0, and the count starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_clk_en | input | 1 | One enabled card-clock cycle |
| src_is_xtal | input | 1 | Card clock is taken directly from the crystal |
| psc_is_32 | input | 1 | Prescaler select: 1 gives 32, 0 gives 31 |
| div_val | input | DIV_W | Divider value; 0 acts as 1 |
| dbl_rate | input | 1 | Halve the ETU (double-rate UART clock) |
| resync | input | 1 | Restart ETU phase |
| etu_tick | output | 1 | End-of-ETU pulse |
| sample_strobe | output | 1 | Mid-ETU sample pulse |

## Verification
The bench targets odd products in double-rate mode. A design that rounds the wrong way, or never adds the leftover cycle, would show ETUs of equal length or the wrong average. It also covers a zero divider, which a faulty design would turn into a huge or zero-length ETU. It drives the double-rate flag while the crystal is the source, where a faulty design would halve the ETU anyway. It pulses resync in mid-ETU and holds the enable low. Here a faulty design would leak a tick, keep a stale phase or alternation bit, or keep counting while stalled. Random settings and enable patterns are compared cycle by cycle against a bench model, and directed period measurements confirm the ETU lengths.

// File: rtl/etu_pkg.sv
package etu_pkg;
    typedef enum logic {
        PH_EARLY = 1'b0,
        PH_LATE  = 1'b1
    } etu_phase_e;

    localparam int unsigned PSC_LO = 31;
    localparam int unsigned PSC_HI = 32;
endpackage

// File: rtl/etu_len_calc.sv
module etu_len_calc
    import etu_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = DIV_W + 5
) (
    input  logic             psc_is_32,
    input  logic [DIV_W-1:0] div_val,
    input  logic             half_en,
    input  logic             alt_extra,
    output logic [CNT_W-1:0] last_idx,
    output logic [CNT_W-1:0] mid_idx
);
    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] full_len;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] etu_len;

    always_comb begin
        div_eff = (div_val == '0) ? CNT_W'(1) : CNT_W'(div_val);
        // 32*D built as a shift, 31*D as 32*D - D
        full_len = (div_eff << 5) - (psc_is_32 ? '0 : div_eff);
        half_len = (full_len >> 1) + CNT_W'(full_len[0] & alt_extra);
        etu_len  = half_en ? half_len : full_len;
        last_idx = etu_len - CNT_W'(1);
        mid_idx  = last_idx >> 1;
    end
endmodule

// File: rtl/etu_phase_ctr.sv
module etu_phase_ctr
    import etu_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             resync,
    input  logic [CNT_W-1:0] last_idx,
    input  logic [CNT_W-1:0] mid_idx,
    output logic             alt_q,
    output logic             etu_tick,
    output logic             sample_strobe
);
    etu_phase_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             alt_d;
    logic             tick_d, strb_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        alt_d   = alt_q;
        tick_d  = 1'b0;
        strb_d  = 1'b0;
        if (resync) begin
            // ANY_TO_EARLY
            state_d = PH_EARLY;
            cnt_d   = '0;
            alt_d   = 1'b0;
        end else if (cnt_en) begin
            unique case (state_q)
                PH_EARLY: begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q >= mid_idx) begin
                        // EARLY_TO_LATE
                        strb_d  = 1'b1;
                        state_d = PH_LATE;
                    end
                end
                PH_LATE: begin
                    if (cnt_q >= last_idx) begin
                        // LATE_TO_EARLY
                        tick_d  = 1'b1;
                        cnt_d   = '0;
                        alt_d   = ~alt_q;
                        state_d = PH_EARLY;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: state_d = PH_EARLY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_EARLY;
            cnt_q   <= '0;
            alt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            alt_q   <= alt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            etu_tick      <= 1'b0;
            sample_strobe <= 1'b0;
        end else begin
            etu_tick      <= tick_d;
            sample_strobe <= strb_d;
        end
    end
endmodule

// File: rtl/etu_baud_gen.sv
module etu_baud_gen
    import etu_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_clk_en,
    input  logic             src_is_xtal,
    input  logic             psc_is_32,
    input  logic [DIV_W-1:0] div_val,
    input  logic             dbl_rate,
    input  logic             resync,
    output logic             etu_tick,
    output logic             sample_strobe
);
    localparam int CNT_W = DIV_W + 5;

    logic             half_en;
    logic             alt_q;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] mid_idx;

    assign half_en = dbl_rate & ~src_is_xtal;

    etu_len_calc #(
        .DIV_W (DIV_W),
        .CNT_W (CNT_W)
    ) i_len (
        .psc_is_32 (psc_is_32),
        .div_val   (div_val),
        .half_en   (half_en),
        .alt_extra (alt_q),
        .last_idx  (last_idx),
        .mid_idx   (mid_idx)
    );

    etu_phase_ctr #(
        .CNT_W (CNT_W)
    ) i_ctr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_en        (card_clk_en),
        .resync        (resync),
        .last_idx      (last_idx),
        .mid_idx       (mid_idx),
        .alt_q         (alt_q),
        .etu_tick      (etu_tick),
        .sample_strobe (sample_strobe)
    );
endmodule

// File: rtl/etu_baud_chk.sv
module etu_baud_chk (
    input logic clk,
    input logic rst_n,
    input logic card_clk_en,
    input logic resync,
    input logic etu_tick,
    input logic sample_strobe
);
    a_r6_not_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(etu_tick && sample_strobe));
    a_r6_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        etu_tick |=> !etu_tick);
    a_r5_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);
    a_r8_resync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (!etu_tick && !sample_strobe));
    a_r7_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk_en && !resync) |=> (!etu_tick && !sample_strobe));
endmodule

bind etu_baud_gen etu_baud_chk i_etu_baud_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .card_clk_en   (card_clk_en),
    .resync        (resync),
    .etu_tick      (etu_tick),
    .sample_strobe (sample_strobe)
);

// File: tb/test_etu_baud_gen.sv
module test_etu_baud_gen;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             card_clk_en = 1'b0;
    logic             src_is_xtal = 1'b0;
    logic             psc_is_32 = 1'b0;
    logic [DIV_W-1:0] div_val = 8'd1;
    logic             dbl_rate = 1'b0;
    logic             resync = 1'b0;
    logic             etu_tick;
    logic             sample_strobe;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit model_on = 1'b0;
    bit done     = 1'b0;

    etu_baud_gen #(.DIV_W(DIV_W)) i_etu_baud_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_clk_en   (card_clk_en),
        .src_is_xtal   (src_is_xtal),
        .psc_is_32     (psc_is_32),
        .div_val       (div_val),
        .dbl_rate      (dbl_rate),
        .resync        (resync),
        .etu_tick      (etu_tick),
        .sample_strobe (sample_strobe)
    );

    always #5 clk = ~clk;

    // ETU length from the requirements (R1..R4)
    function automatic int exp_len(bit p32, int d, bit dbl, bit xtal, bit alt);
        int prod;
        int dd;
        dd   = (d == 0) ? 1 : d;                 // R2
        prod = (p32 ? 32 : 31) * dd;             // R1
        if (dbl && !xtal)                        // R3, R4
            return prod / 2 + ((prod % 2 == 1 && alt) ? 1 : 0);
        return prod;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // reference model
    int m_cnt = 0;
    bit m_alt = 1'b0;
    bit m_tick = 1'b0;
    bit m_strb = 1'b0;

    always @(posedge clk) begin
        int len;
        cyc <= cyc + 1;
        len = exp_len(psc_is_32, int'(div_val), dbl_rate, src_is_xtal, m_alt);
        m_tick <= 1'b0;
        m_strb <= 1'b0;
        if (!rst_n || resync) begin             // R8, R9
            m_cnt <= 0;
            m_alt <= 1'b0;
        end else if (card_clk_en) begin          // R7
            if (m_cnt == (len - 1) / 2) m_strb <= 1'b1;   // R5
            if (m_cnt >= len - 1) begin                    // R6
                m_tick <= 1'b1;
                m_cnt  <= 0;
                m_alt  <= ~m_alt;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            if (m_tick || etu_tick)
                check(m_tick == etu_tick, "R6 tick vs model", int'(etu_tick), int'(m_tick));
            if (m_strb || sample_strobe)
                check(m_strb == sample_strobe, "R5 strobe vs model",
                      int'(sample_strobe), int'(m_strb));
        end
    end

    always @(negedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    task automatic setup(bit p32, int d, bit dbl, bit xtal);
        @(negedge clk);
        psc_is_32   = p32;
        div_val     = DIV_W'(d);
        dbl_rate    = dbl;
        src_is_xtal = xtal;
        resync      = 1'b1;
        @(negedge clk);
        resync      = 1'b0;
    endtask

    task automatic measure(output int n);
        while (!etu_tick) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!etu_tick);
    endtask

    initial begin
        int n;
        int quiet;
        void'($urandom(32'h5eed_0042));

        // R9: outputs low during reset
        repeat (3) @(negedge clk);
        check(!etu_tick && !sample_strobe, "R9 reset outputs", int'(etu_tick | sample_strobe), 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        card_clk_en = 1'b1;

        // R1: 31 x 12 and 32 x 3
        setup(1'b0, 12, 1'b0, 1'b0);
        measure(n); check(n == 372, "R1 psc31 d12", n, 372);
        setup(1'b1, 3, 1'b0, 1'b0);
        measure(n); check(n == 96, "R1 psc32 d3", n, 96);

        // R2: divider 0 behaves like 1
        setup(1'b0, 0, 1'b0, 1'b0);
        measure(n); check(n == 31, "R2 div0", n, 31);

        // R3: odd product halved, alternating 15 / 16
        setup(1'b0, 1, 1'b1, 1'b0);
        measure(n); check(n == 16, "R3 odd half second ETU", n, 16);
        measure(n); check(n == 15, "R3 odd half third ETU", n, 15);
        setup(1'b1, 5, 1'b1, 1'b0);
        measure(n); check(n == 80, "R3 even half", n, 80);

        // R4: crystal source ignores double rate
        setup(1'b1, 2, 1'b1, 1'b1);
        measure(n); check(n == 64, "R4 xtal ignores dbl", n, 64);

        // R7: enable held low, nothing pulses
        setup(1'b0, 1, 1'b0, 1'b0);
        card_clk_en = 1'b0;
        quiet = 0;
        repeat (100) begin
            @(negedge clk);
            quiet += int'(etu_tick | sample_strobe);
        end
        check(quiet == 0, "R7 stalled outputs", quiet, 0);
        card_clk_en = 1'b1;

        // R8: repeated mid-ETU resync keeps ticks away
        setup(1'b0, 1, 1'b0, 1'b0);
        quiet = 0;
        repeat (10) begin
            repeat (20) begin
                @(negedge clk);
                quiet += int'(etu_tick);
            end
            resync = 1'b1;
            @(negedge clk);
            resync = 1'b0;
            quiet += int'(etu_tick);
        end
        check(quiet == 0, "R8 resync restarts phase", quiet, 0);

        // random settings and enable patterns, checked by the model
        for (int s = 0; s < 40; s++) begin
            setup(1'($urandom), int'($urandom_range(0, 15)), 1'($urandom), 1'($urandom));
            for (int k = 0; k < 1200; k++) begin
                @(negedge clk);
                card_clk_en = ($urandom_range(0, 9) < 7);
                resync = ($urandom_range(0, 999) == 0);
            end
            resync = 1'b0;
            card_clk_en = 1'b1;
        end

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule